// File: doc/BRIEF.md
# SPI Shadow-Register Sync Sequencer

This block holds a local copy of a peripheral's byte-wide register map and keeps the device in step with it over a four-wire SPI master. A host writes entries through a simple one-cycle write port. Each accepted write updates the local copy and flags the entry as pending. When any entry is pending and the block is idle, it starts a sync pass on the next cycle.

A pass always runs the same ordered steps. The first pass after reset reads the device's interface-setup register at address 0x000 and rewrites it with 0x3C if it holds anything else. Next, if any entry in the table region 0x100..0x17F is pending, the whole region goes out as two auto-increment bursts, and a throwaway write to the unused address 0x00A follows them. The other pending registers then go out one frame each. If the pass sent any register in the 0x011..0x013 group, it ends by reading the status register 0x014 and showing the result on the readback output.

Top module: `spi_shadow_sync`

## Requirements
- R1: The first pass after reset reads address 0x000 (read frame, bit 23 = 1). It writes 0x3C there only if the value read differs from 0x3C. Later passes do neither.
- R2: When any table entry (0x100..0x17F) is pending, the pass sends two write bursts with CS held low, each carrying 64 data bytes. The first begins at 0x100 and the second at 0x140. The bytes are the local values in ascending address order.
- R3: One write of data 0x00 to address 0x00A follows the second table burst. It is sent in no pass that lacks the bursts.
- R4: Every other pending register is sent as one 24-bit frame: bit 23 is the read flag (0 = write), bits 22..8 the address and bits 7..0 the data, MSB first in SPI mode 0 (MOSI stable while SCLK is high). These frames come after the table phase, in ascending address order.
- R5: When the pass sent a register in 0x011..0x013, it ends with a read of 0x014 and `readback` holds the byte read. Otherwise 0x014 is not read and `readback` keeps its value.
- R6: Each pending register is sent once per pass. A host write to an entry that this pass has already sent marks it pending again. A new pass then starts without further action, and it carries the new value.
- R7: Host writes to address 0x000, or to an address at or above NUM_REGS, are ignored: they start no pass and change nothing on the device.
- R8: `busy` is high for the whole pass. `done` is a one-cycle pulse in the last busy cycle. While idle, CS is high.
- R9: SCLK runs at 2*SCLK_HALF system clocks per period and is low whenever CS is high. CS stays high for at least two SCLK periods between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 15 | Host register address |
| hostData | input | 8 | Host register data |
| sclk | output | 1 | SPI clock (mode 0) |
| mosi | output | 1 | SPI data to device |
| miso | input | 1 | SPI data from device |
| csn | output | 1 | SPI chip select, active low |
| busy | output | 1 | Sync pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| readback | output | 8 | Last status byte read from 0x014 |

## Verification
Fault symptoms by kind:
- A wrong pending flag shows on the SPI lines within the same pass, as a missing frame or a repeated write. The write counts per address reveal it when the pass ends.
- A wrong phase or sequence step changes the order or the number of frames. This shows as a burst with the wrong byte count, a throwaway write where none belongs, or a status read with no trigger. Each appears within one pass.
- A wrong configuration cache shows as an extra read or write of address 0x000, and the counters catch it after that pass.
- Faults in the SPI engine give corrupt data bytes, CS gaps that are too short, or MOSI moving under a high SCLK. The corrupt bytes are found after the next pass; the SPI-line assertions fire within cycles.

// File: rtl/spi_sync_pkg.sv
package spi_sync_pkg;
  localparam int ADDR_W = 15;
  localparam logic [7:0] CFG_VALUE = 8'h3C;
  localparam logic [ADDR_W-1:0] CFG_ADDR = 15'h000;
  localparam logic [ADDR_W-1:0] LUT_FIRST = 15'h100;
  localparam logic [ADDR_W-1:0] LUT_SECOND = 15'h140;
  localparam logic [ADDR_W-1:0] LUT_LAST = 15'h17F;
  localparam logic [ADDR_W-1:0] FLUSH_ADDR = 15'h00A;
  localparam logic [ADDR_W-1:0] FAST_LO = 15'h011;
  localparam logic [ADDR_W-1:0] FAST_HI = 15'h013;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 15'h014;
  localparam int BURST_DATA = 64;

  typedef enum logic [2:0] {SEL_HI, SEL_LO, SEL_MEM, SEL_CFG, SEL_ZERO} txSel_e;

  typedef struct packed {
    logic   load;
    logic   gap;
    logic   csLow;
    logic   rw;
    logic   capRb;
    txSel_e sel;
  } dpCtl_t;
endpackage

// File: rtl/spi_sync_dp.sv
module spi_sync_dp
  import spi_sync_pkg::*;
#(
  parameter int NUM_REGS  = 384,
  parameter int SCLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostData,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              csn,
  output logic              engBusy,
  output logic [7:0]        rxByte,
  output logic              anyDirty,
  output logic              lutDirty,
  output logic              curDirty,
  output logic [7:0]        readback
);
  localparam int IDXW = $clog2(NUM_REGS);
  localparam int DIVW = $clog2(SCLK_HALF) + 1;
  localparam int LUT_LO_I = int'(LUT_FIRST);
  localparam int LUT_HI_I = int'(LUT_LAST);

  logic [7:0] shadow [NUM_REGS];
  logic [NUM_REGS-1:0] dirty;
  logic hostOk, curIn, clrHit;
  logic [IDXW-1:0] hostIdx, curIdx;
  logic [7:0] memByte, txByte;

  assign hostOk  = hostWe && (hostAddr != '0) && (hostAddr < ADDR_W'(NUM_REGS));
  assign curIn   = curAddr < ADDR_W'(NUM_REGS);
  assign hostIdx = hostAddr[IDXW-1:0];
  assign curIdx  = curAddr[IDXW-1:0];
  assign clrHit  = ctl.load && (ctl.sel == SEL_MEM) && curIn;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        dirty[g]  <= 1'b0;
        shadow[g] <= '0;
      end else if (hostOk && hostIdx == IDXW'(g)) begin
        dirty[g]  <= 1'b1;
        shadow[g] <= hostData;
      end else if (clrHit && curIdx == IDXW'(g)) begin
        dirty[g]  <= 1'b0;
      end
    end
  end

  assign anyDirty = |dirty;
  assign lutDirty = |dirty[LUT_HI_I:LUT_LO_I];
  assign curDirty = curIn ? dirty[curIdx] : 1'b0;
  assign memByte  = curIn ? shadow[curIdx] : 8'h00;

  always_comb begin
    case (ctl.sel)
      SEL_HI:  txByte = {ctl.rw, curAddr[14:8]};
      SEL_LO:  txByte = curAddr[7:0];
      SEL_MEM: txByte = memByte;
      SEL_CFG: txByte = CFG_VALUE;
      default: txByte = 8'h00;
    endcase
  end

  // Byte engine: 16 half periods per byte, SCLK suppressed in gap mode.
  logic engOn, gapMode, sclkR, csnR;
  logic [DIVW-1:0] divCnt;
  logic [3:0] halfCnt;
  logic [7:0] shReg, rxReg, rbReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      engOn <= 1'b0; gapMode <= 1'b0; sclkR <= 1'b0; csnR <= 1'b1;
      divCnt <= '0; halfCnt <= '0; shReg <= '0; rxReg <= '0; rbReg <= '0;
    end else begin
      csnR <= ~ctl.csLow;
      if (ctl.capRb) rbReg <= rxReg;
      if (ctl.load) begin
        engOn <= 1'b1; gapMode <= ctl.gap; shReg <= txByte;
        divCnt <= '0; halfCnt <= '0; sclkR <= 1'b0;
      end else if (engOn) begin
        if (divCnt == DIVW'(SCLK_HALF - 1)) begin
          divCnt  <= '0;
          halfCnt <= halfCnt + 4'd1;
          if (!gapMode) begin
            sclkR <= ~sclkR;
            if (!sclkR) rxReg <= {rxReg[6:0], miso};
            else        shReg <= {shReg[6:0], 1'b0};
          end
          if (halfCnt == 4'd15) engOn <= 1'b0;
        end else begin
          divCnt <= divCnt + DIVW'(1);
        end
      end
    end
  end

  assign sclk     = sclkR;
  assign mosi     = shReg[7];
  assign csn      = csnR;
  assign engBusy  = engOn;
  assign rxByte   = rxReg;
  assign readback = rbReg;
endmodule

// File: rtl/spi_sync_ctrl.sv
module spi_sync_ctrl
  import spi_sync_pkg::*;
#(
  parameter int NUM_REGS = 384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              engBusy,
  input  logic [7:0]        rxByte,
  input  logic              anyDirty,
  input  logic              lutDirty,
  input  logic              curDirty,
  output dpCtl_t            ctl,
  output logic [ADDR_W-1:0] curAddr,
  output logic              busy,
  output logic              done
);
  localparam logic [6:0] LAST_SINGLE = 7'd2;
  localparam logic [6:0] LAST_BURST  = 7'(BURST_DATA + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_DECIDE, ST_LOAD, ST_WAIT, ST_GAP, ST_GAPW, ST_ADV, ST_DONE} state_e;
  typedef enum logic [2:0] {PH_CFGRD, PH_CFGWR, PH_LUT0, PH_LUT1, PH_FLUSH, PH_SCAN, PH_STAT} phase_e;

  state_e state;
  phase_e phase;
  logic [6:0] byteIdx, lastIdx;
  logic rwR, cfgOk, fastHit, inBurst;

  assign inBurst = (phase == PH_LUT0) || (phase == PH_LUT1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; phase <= PH_CFGRD; curAddr <= '0;
      byteIdx <= '0; lastIdx <= '0; rwR <= 1'b0; cfgOk <= 1'b0; fastHit <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (anyDirty) begin
          fastHit <= 1'b0;
          phase   <= cfgOk ? PH_LUT0 : PH_CFGRD;
          state   <= ST_DECIDE;
        end
        ST_DECIDE: begin
          byteIdx <= '0; lastIdx <= LAST_SINGLE; rwR <= 1'b0;
          case (phase)
            PH_CFGRD: begin curAddr <= CFG_ADDR; rwR <= 1'b1; state <= ST_LOAD; end
            PH_CFGWR: begin curAddr <= CFG_ADDR; state <= ST_LOAD; end
            PH_LUT0: if (lutDirty) begin
              curAddr <= LUT_FIRST; lastIdx <= LAST_BURST; state <= ST_LOAD;
            end else begin
              phase <= PH_SCAN; curAddr <= ADDR_W'(1);
            end
            PH_LUT1:  begin curAddr <= LUT_SECOND; lastIdx <= LAST_BURST; state <= ST_LOAD; end
            PH_FLUSH: begin curAddr <= FLUSH_ADDR; state <= ST_LOAD; end
            PH_SCAN: begin
              if (curAddr >= ADDR_W'(NUM_REGS)) phase <= PH_STAT;
              else if (curAddr >= LUT_FIRST && curAddr <= LUT_LAST) curAddr <= LUT_LAST + ADDR_W'(1);
              else if (curDirty) begin
                state <= ST_LOAD;
                if (curAddr >= FAST_LO && curAddr <= FAST_HI) fastHit <= 1'b1;
              end else curAddr <= curAddr + ADDR_W'(1);
            end
            default: if (fastHit) begin
              curAddr <= STATUS_ADDR; rwR <= 1'b1; state <= ST_LOAD;
            end else state <= ST_DONE;
          endcase
        end
        ST_LOAD: begin
          state <= ST_WAIT;
          if (inBurst && byteIdx >= 7'd2) curAddr <= curAddr + ADDR_W'(1);
        end
        ST_WAIT: if (!engBusy) begin
          if (byteIdx == lastIdx) state <= ST_GAP;
          else begin byteIdx <= byteIdx + 7'd1; state <= ST_LOAD; end
        end
        ST_GAP:  state <= ST_GAPW;
        ST_GAPW: if (!engBusy) state <= ST_ADV;
        ST_ADV: begin
          state <= ST_DECIDE;
          case (phase)
            PH_CFGRD: if (rxByte == CFG_VALUE) begin cfgOk <= 1'b1; phase <= PH_LUT0; end
                      else phase <= PH_CFGWR;
            PH_CFGWR: begin cfgOk <= 1'b1; phase <= PH_LUT0; end
            PH_LUT0:  phase <= PH_LUT1;
            PH_LUT1:  phase <= PH_FLUSH;
            PH_FLUSH: begin phase <= PH_SCAN; curAddr <= ADDR_W'(1); end
            PH_SCAN:  curAddr <= curAddr + ADDR_W'(1);
            default:  state <= ST_DONE;
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load  = (state == ST_LOAD) || (state == ST_GAP);
    ctl.gap   = (state == ST_GAP);
    ctl.csLow = (state == ST_LOAD) || (state == ST_WAIT);
    ctl.rw    = rwR;
    ctl.capRb = (state == ST_ADV) && (phase == PH_STAT);
    if (state == ST_GAP)      ctl.sel = SEL_ZERO;
    else if (byteIdx == 7'd0) ctl.sel = SEL_HI;
    else if (byteIdx == 7'd1) ctl.sel = SEL_LO;
    else begin
      case (phase)
        PH_CFGWR:                   ctl.sel = SEL_CFG;
        PH_LUT0, PH_LUT1, PH_SCAN:  ctl.sel = SEL_MEM;
        default:                    ctl.sel = SEL_ZERO;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/spi_shadow_sync.sv
module spi_shadow_sync
  import spi_sync_pkg::*;
#(
  parameter int NUM_REGS  = 384,
  parameter int SCLK_HALF = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hostWe,
  input  logic [14:0] hostAddr,
  input  logic [7:0]  hostData,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        csn,
  output logic        busy,
  output logic        done,
  output logic [7:0]  readback
);
  dpCtl_t ctl;
  logic [ADDR_W-1:0] curAddr;
  logic engBusy, anyDirty, lutDirty, curDirty;
  logic [7:0] rxByte;

  spi_sync_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rst(rst), .engBusy(engBusy), .rxByte(rxByte), .anyDirty(anyDirty),
    .lutDirty(lutDirty), .curDirty(curDirty), .ctl(ctl), .curAddr(curAddr),
    .busy(busy), .done(done)
  );

  spi_sync_dp #(.NUM_REGS(NUM_REGS), .SCLK_HALF(SCLK_HALF)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .curAddr(curAddr), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostData(hostData), .miso(miso), .sclk(sclk), .mosi(mosi),
    .csn(csn), .engBusy(engBusy), .rxByte(rxByte), .anyDirty(anyDirty),
    .lutDirty(lutDirty), .curDirty(curDirty), .readback(readback)
  );
endmodule

// File: rtl/spi_shadow_sync_chk.sv
module spi_shadow_sync_chk (
  input logic       clk,
  input logic       rst,
  input logic       sclk,
  input logic       mosi,
  input logic       csn,
  input logic       busy,
  input logic       done,
  input logic [7:0] readback
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (rst) done |-> busy);
  p_idle_cs_high_r8: assert property (@(posedge clk) disable iff (rst) !busy |-> csn);
  p_sclk_low_cs_high_r9: assert property (@(posedge clk) disable iff (rst) csn |-> !sclk);
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!csn && sclk && $past(sclk)) |-> $stable(mosi));
  p_rb_hold_idle_r5: assert property (@(posedge clk) disable iff (rst) !busy |=> $stable(readback));
endmodule

bind spi_shadow_sync spi_shadow_sync_chk u_chk (.*);

// File: tb/spi_shadow_sync_bench.sv
module spi_shadow_sync_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF = 2;
  localparam int NUM_REGS = 384;
  localparam logic [22:0] VEC [4] = '{
    {15'h020, 8'h55}, {15'h0FF, 8'hA1}, {15'h001, 8'h7E}, {15'h0A0, 8'hC3}};

  logic clk = 0, rst = 1, hostWe = 0, miso = 0;
  logic [14:0] hostAddr = '0;
  logic [7:0] hostData = '0;
  logic sclk, mosi, csn, busy, done;
  logic [7:0] readback;

  spi_shadow_sync #(.NUM_REGS(NUM_REGS), .SCLK_HALF(SCLK_HALF)) u_spi_shadow_sync (
    .clk(clk), .rst(rst), .hostWe(hostWe), .hostAddr(hostAddr), .hostData(hostData),
    .sclk(sclk), .mosi(mosi), .miso(miso), .csn(csn), .busy(busy), .done(done),
    .readback(readback));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFail = 0, cyc = 0;
  logic [7:0] devMem [512];
  logic [7:0] expMem [512];
  int wrCnt [512];
  int wrT [512];
  int cfgRd = 0, cfgWr = 0, statRd = 0, burstCnt = 0, lutBytes = 0, flushWr = 0, lutT = 0, flushT = 0;

  // Device model: mode 0, header of read flag + 15-bit address, then auto-increment bytes.
  logic [23:0] dSr = '0;
  int dBits = 0, frameBytes = 0;
  logic dRw = 0, prevCsn = 1;
  logic [14:0] dAddr = '0;
  always @(posedge sclk or negedge csn or posedge csn) begin
    if (csn !== prevCsn) begin
      if (!csn) begin dBits = 0; frameBytes = 0; end
      else if (!dRw && frameBytes == 64) burstCnt++;
      prevCsn = csn;
    end else if (sclk && !csn) begin
      dSr = {dSr[22:0], mosi};
      dBits++;
      if (dBits == 16) begin
        dRw = dSr[15]; dAddr = dSr[14:0];
        if (dRw && dAddr == 15'h000) cfgRd++;
        if (dRw && dAddr == 15'h014) statRd++;
      end else if (dBits > 16 && dBits % 8 == 0) begin
        if (!dRw) begin
          devMem[dAddr[8:0]] = dSr[7:0];
          wrCnt[dAddr[8:0]]++;
          wrT[dAddr[8:0]] = cyc;
          if (dAddr == 15'h000) cfgWr++;
          if (dAddr == 15'h00A) begin flushWr++; flushT = cyc; end
          if (dAddr >= 15'h100 && dAddr <= 15'h17F) begin lutBytes++; lutT = cyc; end
        end
        dAddr++; frameBytes++;
      end
    end
  end
  always @(negedge sclk)
    if (!csn && dBits >= 16 && dRw) miso = devMem[dAddr[8:0]][7 - ((dBits - 16) % 8)];

  // Line timing monitors
  int gapRun = 0, minGap = 1000000, lastRise = -1, minPer = 1000000;
  logic seenFrame = 0, prevSclk = 0;
  always @(negedge clk) begin
    cyc++;
    if (csn) gapRun++;
    else begin
      if (seenFrame && gapRun > 0 && gapRun < minGap) minGap = gapRun;
      seenFrame = 1; gapRun = 0;
    end
    if (sclk && !prevSclk) begin
      if (lastRise >= 0 && cyc - lastRise < minPer) minPer = cyc - lastRise;
      lastRise = cyc;
    end
    prevSclk = sclk;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWe = 1; hostAddr = a; hostData = d;
    if (a != 0 && a < NUM_REGS) expMem[a[8:0]] = d;
    @(negedge clk);
    hostWe = 0;
  endtask

  task automatic waitDone();
    @(negedge clk);
    while (!done) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL R8 watchdog: actual=timeout expected=pass completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin devMem[i] = 8'h00; expMem[i] = 8'h00; wrCnt[i] = 0; wrT[i] = 0; end
    doReset();
    @(negedge clk);
    chk("R8", "reset busy", busy, 0);
    chk("R8", "reset done", done, 0);
    chk("R8", "reset csn", csn, 1);
    chk("R9", "reset sclk", sclk, 0);
    chk("R5", "reset readback", readback, 0);

    // Table of single-register vectors
    for (int v = 0; v < 4; v++) begin
      hostWrite(VEC[v][22:8], VEC[v][7:0]);
      waitDone();
      chk("R4", "single write value", devMem[VEC[v][16:8]], VEC[v][7:0]);
      chk("R6", "written once", wrCnt[VEC[v][16:8]], 1);
      if (v == 0) begin
        chk("R1", "first pass cfg read", cfgRd, 1);
        chk("R1", "cfg rewritten", cfgWr, 1);
        chk("R1", "cfg value", devMem[0], 8'h3C);
      end
    end
    chk("R1", "no later cfg read", cfgRd, 1);
    chk("R3", "no flush without table", flushWr, 0);
    chk("R2", "no burst without table", burstCnt, 0);

    // Ascending order of two pending registers
    hostWrite(15'h050, 8'h12);
    hostWrite(15'h030, 8'h34);
    waitDone();
    chk("R4", "ascending order", (wrT[9'h030] < wrT[9'h050]) ? 1 : 0, 1);
    chk("R4", "reg 0x030", devMem[9'h030], 8'h34);

    // Table region
    hostWrite(15'h105, 8'hA5);
    hostWrite(15'h160, 8'h5A);
    hostWrite(15'h022, 8'h33);
    waitDone();
    chk("R2", "burst count", burstCnt, 2);
    chk("R2", "table bytes", lutBytes, 128);
    begin
      int bad = 0;
      for (int a = 256; a < 384; a++) if (devMem[a] !== expMem[a]) bad++;
      chk("R2", "table content mismatches", bad, 0);
    end
    chk("R3", "flush writes", flushWr, 1);
    chk("R3", "flush after table", (flushT > lutT) ? 1 : 0, 1);
    chk("R3", "flush data", devMem[9'h00A], 0);
    chk("R4", "single after table", (wrT[9'h022] > flushT) ? 1 : 0, 1);

    // Fast-latch group
    devMem[9'h014] = 8'h6B;
    hostWrite(15'h012, 8'h01);
    waitDone();
    chk("R5", "status read", statRd, 1);
    chk("R5", "readback value", readback, 8'h6B);
    devMem[9'h014] = 8'h11;
    hostWrite(15'h040, 8'h02);
    waitDone();
    chk("R5", "no status read", statRd, 1);
    chk("R5", "readback kept", readback, 8'h6B);

    // Re-pend during pass
    hostWrite(15'h060, 8'h11);
    while (wrCnt[9'h060] == 0) @(negedge clk);
    hostWrite(15'h060, 8'h22);
    waitDone();
    begin
      int seen = 0;
      for (int k = 0; k < 4; k++) begin @(negedge clk); if (busy) seen = 1; end
      chk("R6", "auto restart", seen, 1);
    end
    waitDone();
    chk("R6", "new value sent", devMem[9'h060], 8'h22);
    chk("R6", "sent twice", wrCnt[9'h060], 2);

    // Ignored writes
    repeat (4) @(negedge clk);
    begin
      int seen = 0;
      hostWrite(15'h000, 8'h77);
      hostWrite(15'h200, 8'h99);
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (busy) seen = 1; end
      chk("R7", "no pass started", seen, 0);
      chk("R7", "cfg unchanged", devMem[0], 8'h3C);
    end

    chk("R9", "min CS gap", (minGap >= 4 * SCLK_HALF) ? 1 : 0, 1);
    chk("R9", "SCLK period", minPer, 2 * SCLK_HALF);

    // Reset again: cfg already correct, read but no write
    doReset();
    hostWrite(15'h070, 8'h05);
    waitDone();
    chk("R1", "cfg read after reset", cfgRd, 2);
    chk("R1", "no cfg write when matching", cfgWr, 1);
    chk("R4", "reg 0x070", devMem[9'h070], 8'h05);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule